// File: doc/BRIEF.md
# Key Matrix Serial Slave Interface

This block is the host-facing serial port of a key matrix controller. A host talks to it over four wires: a chip-enable line, a serial clock, a data input and an open-drain data output. Each transaction starts with an 8-bit address. The address is clocked in while chip enable is low, least-significant bit first. Chip enable then rises, and the address that was captured decides what happens next. One code opens a 16-bit control write, which loads the key-line levels, the port levels and the port/key-line split. The other code opens a read, which streams out 30 bits of confirmed key data.

Outside a transfer the data output acts as a request flag. The key scan engine pulses `key_ready_i` when it has confirmed key data. From then on the block pulls the line low whenever chip enable is low. A completed read releases the line and pulses `rd_done_o` back to the scan engine. All serial inputs are asynchronous to `clk_i` and pass through a synchronizer before any decision is taken. The control outputs feed the pin multiplexer, which lies outside this block.

Top module: `kss_serial_slave`

## Requirements
- R1: While `rst_ni` is low, `kc_o`, `pc_o` and `kp_o` are all zero and `sdo_pull_o` is 0 (line released). This holds even if a read frame or a `key_ready_i` pulse arrives during reset. After reset is released, the line stays high until new key data is signalled.
- R2: The address is sampled on rising serial-clock edges while chip enable is low, least-significant bit first. The value 0x62 opens a control write and 0x63 opens a key-data read.
- R3: Write payload bits are numbered 0..15 in arrival order. Bits 0..5 go to `kc_o[0..5]`, bits 8..11 to `pc_o[0..3]` and bits 14..15 to `kp_o[0..1]`. Bits 6, 7, 12 and 13 are ignored whatever their value.
- R4: The control outputs change only once the 16th payload bit has been sampled, all fields at once. A frame that ends with fewer than 16 bits leaves them unchanged. Bits after the 16th in the same frame are ignored.
- R5: In a read, key data bit k (`key_data_i[k]`, k = 0..29) appears on the line. Bit 0 is valid after chip enable rises, and bit k after the k-th falling serial-clock edge. A 0 bit pulls the line low (`sdo_pull_o` = 1) and a 1 bit releases it.
- R6: While chip enable is high in a write frame or an ignored frame, `sdo_pull_o` is 0.
- R7: After a `key_ready_i` pulse, `sdo_pull_o` is 1 whenever chip enable is low, until the request is cleared.
- R8: Chip enable falling at the end of a read frame clears the request, so the line is released, and gives a one-cycle `rd_done_o` pulse. No other frame produces that pulse.
- R9: An address other than 0x62 or 0x63 makes the block ignore the rest of the frame until chip enable next falls. The control outputs do not change, the line is released and `rd_done_o` is not pulsed.
- R10: A frame with fewer than 8 address bits before chip enable rises is treated as an invalid address.
- R11: Key data is captured when chip enable rises at the start of a read. Changes on `key_data_i` during the frame do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial chip enable (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in (asynchronous) |
| sdo_pull_o | output | 1 | Open-drain drive: 1 pulls the data line low |
| key_data_i | input | 30 | Confirmed key data from the scan engine, bit k is key k+1 |
| key_ready_i | input | 1 | One-cycle pulse: new confirmed key data available |
| rd_done_o | output | 1 | One-cycle pulse when a key-data read completes |
| kc_o | output | 6 | Key-line level settings |
| pc_o | output | 4 | General-purpose port levels |
| kp_o | output | 2 | Port/key-line split select |

## Verification
The assertions assume that every level on `ce_i`, `sclk_i` and `sdi_i` is held for several system clocks, longer than the synchronizer plus the edge detector. They also assume that the serial clock is low whenever chip enable changes, so no chip-enable edge coincides with a serial-clock edge. The stimulus holds each serial half-period for 8 to 12 system clocks. It moves chip enable only with the serial clock low and gives `key_ready_i` as a single-cycle pulse. Line levels are sampled at least four system clocks after the last serial event, when the synchronized state has settled.

// File: rtl/kss_pkg.sv
package kss_pkg;
  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_SKIP = 2'd3
  } kss_state_e;
endpackage

// File: rtl/kss_sync.sv
module kss_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kss_frame.sv
module kss_frame
  import kss_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               WR_W    = 16,
  parameter int               RD_W    = 30,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h62,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'h63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_s_i,
  input  logic            sclk_s_i,
  input  logic            sdi_s_i,
  input  logic [RD_W-1:0] key_data_i,
  input  logic            key_ready_i,
  output logic            wr_load_o,
  output logic [WR_W-1:0] wr_data_o,
  output logic            rd_done_o,
  output logic            sdo_pull_o
);
  localparam int AC_W = $clog2(ADDR_W + 1);
  localparam int WC_W = $clog2(WR_W + 1);

  kss_state_e      st_q;
  logic            ce_d_q, sclk_d_q;
  logic [ADDR_W-1:0] a_sh_q;
  logic [AC_W-1:0] a_cnt_q;
  logic [WR_W-1:0] w_sh_q;
  logic [WC_W-1:0] w_cnt_q;
  logic [RD_W-1:0] r_sh_q;
  logic            req_q, wr_load_q, rd_done_q;

  logic ce_rise, ce_fall, sclk_rise, sclk_fall, addr_full, rd_end;
  assign ce_rise   = ce_s_i & ~ce_d_q;
  assign ce_fall   = ~ce_s_i & ce_d_q;
  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign sclk_fall = ~sclk_s_i & sclk_d_q;
  assign addr_full = (a_cnt_q == AC_W'(ADDR_W));
  assign rd_end    = ce_fall && (st_q == ST_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d_q   <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      ce_d_q   <= ce_s_i;
      sclk_d_q <= sclk_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ADDR;
      a_sh_q    <= '0;
      a_cnt_q   <= '0;
      w_sh_q    <= '0;
      w_cnt_q   <= '0;
      r_sh_q    <= '0;
      wr_load_q <= 1'b0;
      rd_done_q <= 1'b0;
    end else begin
      wr_load_q <= 1'b0;
      rd_done_q <= 1'b0;
      if (ce_fall) begin
        st_q    <= ST_ADDR;
        a_cnt_q <= '0;
        if (st_q == ST_RD) rd_done_q <= 1'b1;
      end else if (ce_rise) begin
        if (addr_full && a_sh_q == WR_ADDR) begin
          st_q    <= ST_WR;
          w_cnt_q <= '0;
        end else if (addr_full && a_sh_q == RD_ADDR) begin
          st_q   <= ST_RD;
          r_sh_q <= key_data_i;
        end else begin
          st_q <= ST_SKIP;
        end
      end else begin
        case (st_q)
          ST_ADDR: if (sclk_rise) begin
            // lsb first: newest bit enters at the top
            a_sh_q <= {sdi_s_i, a_sh_q[ADDR_W-1:1]};
            if (!addr_full) a_cnt_q <= a_cnt_q + 1'b1;
          end
          ST_WR: if (sclk_rise && w_cnt_q != WC_W'(WR_W)) begin
            w_sh_q  <= {sdi_s_i, w_sh_q[WR_W-1:1]};
            w_cnt_q <= w_cnt_q + 1'b1;
            if (w_cnt_q == WC_W'(WR_W - 1)) wr_load_q <= 1'b1;
          end
          ST_RD: if (sclk_fall) r_sh_q <= {1'b0, r_sh_q[RD_W-1:1]};
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_q <= 1'b0;
    else if (key_ready_i) req_q <= 1'b1;
    else if (rd_end)      req_q <= 1'b0;
  end

  always_comb begin
    case (st_q)
      ST_ADDR: sdo_pull_o = req_q;
      ST_RD:   sdo_pull_o = ~r_sh_q[0];
      default: sdo_pull_o = 1'b0;
    endcase
  end

  assign wr_load_o = wr_load_q;
  assign wr_data_o = w_sh_q;
  assign rd_done_o = rd_done_q;

  // R8
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_q && !key_ready_i && !$past(key_ready_i)) |-> !req_q);

  // R7
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(key_ready_i));

  // R4
  wcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_cnt_q <= WC_W'(WR_W)));
endmodule

// File: rtl/kss_ctrl_reg.sv
module kss_ctrl_reg #(
  parameter int WR_W  = 16,
  parameter int KC_N  = 6,
  parameter int PC_N  = 4,
  parameter int KP_N  = 2,
  parameter int GAP_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WR_W-1:0] data_i,
  output logic [KC_N-1:0] kc_o,
  output logic [PC_N-1:0] pc_o,
  output logic [KP_N-1:0] kp_o
);
  localparam int KC_LSB = 0;
  localparam int PC_LSB = KC_LSB + KC_N + GAP_N;
  localparam int KP_LSB = PC_LSB + PC_N + GAP_N;
  localparam int CT_W   = KC_N + PC_N + KP_N;

  logic [CT_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (load_i) ctrl_q <= {data_i[KP_LSB +: KP_N],
                                data_i[PC_LSB +: PC_N],
                                data_i[KC_LSB +: KC_N]};
  end

  assign kc_o = ctrl_q[0 +: KC_N];
  assign pc_o = ctrl_q[KC_N +: PC_N];
  assign kp_o = ctrl_q[KC_N + PC_N +: KP_N];

  // R4
  ctrl_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> $past(load_i));
endmodule

// File: rtl/kss_serial_slave.sv
module kss_serial_slave #(
  parameter int               ADDR_W      = 8,
  parameter int               KC_N        = 6,
  parameter int               PC_N        = 4,
  parameter int               KP_N        = 2,
  parameter int               GAP_N       = 2,
  parameter int               RD_W        = 30,
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] WR_ADDR    = 8'h62,
  parameter logic [ADDR_W-1:0] RD_ADDR    = 8'h63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            sclk_i,
  input  logic            sdi_i,
  output logic            sdo_pull_o,
  input  logic [RD_W-1:0] key_data_i,
  input  logic            key_ready_i,
  output logic            rd_done_o,
  output logic [KC_N-1:0] kc_o,
  output logic [PC_N-1:0] pc_o,
  output logic [KP_N-1:0] kp_o
);
  localparam int WR_W = KC_N + PC_N + KP_N + 2 * GAP_N;

  logic [2:0]      ser_s;
  logic            wr_load;
  logic [WR_W-1:0] wr_data;

  kss_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_i, sclk_i, sdi_i}),
    .q_o    (ser_s)
  );

  kss_frame #(
    .ADDR_W (ADDR_W),
    .WR_W   (WR_W),
    .RD_W   (RD_W),
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_s_i     (ser_s[2]),
    .sclk_s_i   (ser_s[1]),
    .sdi_s_i    (ser_s[0]),
    .key_data_i (key_data_i),
    .key_ready_i(key_ready_i),
    .wr_load_o  (wr_load),
    .wr_data_o  (wr_data),
    .rd_done_o  (rd_done_o),
    .sdo_pull_o (sdo_pull_o)
  );

  kss_ctrl_reg #(
    .WR_W (WR_W),
    .KC_N (KC_N),
    .PC_N (PC_N),
    .KP_N (KP_N),
    .GAP_N(GAP_N)
  ) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_load),
    .data_i(wr_data),
    .kc_o  (kc_o),
    .pc_o  (pc_o),
    .kp_o  (kp_o)
  );

  // R6
  ce_hi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_s[2] && $past(ser_s[2]) && $past(ser_s[2], 2) && !u_frame.rd_end
     && u_frame.st_q != kss_pkg::ST_RD) |-> !sdo_pull_o);
endmodule

// File: tb/kss_serial_slave_tb.sv
module kss_serial_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sdo_pull;
  logic [29:0] key_data = '0;
  logic        key_ready = 1'b0;
  logic        rd_done;
  logic [5:0]  kc;
  logic [3:0]  pc;
  logic [1:0]  kp;

  int total = 0, bad = 0, rd_cnt = 0;
  bit done = 0;
  logic exp_q[$];
  int   tag_q[$];
  event smp_ev;

  always #4 clk = ~clk;

  kss_serial_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_pull_o(sdo_pull), .key_data_i(key_data), .key_ready_i(key_ready),
    .rd_done_o(rd_done), .kc_o(kc), .pc_o(pc), .kp_o(kp)
  );

  always @(posedge clk) if (rd_done) rd_cnt++;

  // monitor: pops expected line levels, compares with the open-drain line
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      logic e;
      int   t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (~sdo_pull !== e) begin
        bad++;
        $display("FAIL R%0d line act=%b exp=%b", t, ~sdo_pull, e);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic expect_line(logic e, int r);
    exp_q.push_back(e);
    tag_q.push_back(r);
    -> smp_ev;
    #1;
  endtask

  task automatic send_bit(logic b);
    sdi = b; tick(4); sclk = 1'b1; tick(8); sclk = 1'b0; tick(4);
  endtask

  task automatic addr_phase(logic [7:0] a, int n);
    for (int i = 0; i < n; i++) send_bit(a[i]);
    tick(2); ce = 1'b1; tick(8);
  endtask

  task automatic pay_bits(logic [15:0] p, int lo, int hi, int r);
    for (int i = lo; i < hi; i++) begin
      send_bit(p[i]);
      expect_line(1'b1, r);
    end
  endtask

  task automatic ce_low; ce = 1'b0; tick(10); endtask

  task automatic ctrl_chk(string r, logic [15:0] p);
    chk(r, {26'd0, kc}, {26'd0, p[5:0]});
    chk(r, {28'd0, pc}, {28'd0, p[11:8]});
    chk(r, {30'd0, kp}, {30'd0, p[15:14]});
  endtask

  task automatic rd_frame(logic [29:0] kd, bit in_rst, bit flip, int r);
    addr_phase(8'h63, 8);
    for (int k = 0; k < 30; k++) begin
      expect_line(in_rst ? 1'b1 : kd[k], r);
      if (flip && k == 2) key_data = ~key_data;
      send_bit(1'b0);
    end
    ce_low();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung (all requirements)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] p1, p2;
    logic [29:0] kd1, kd2;
    p1 = {2'b10, 2'b11, 4'b0110, 2'b11, 6'b101101};
    p2 = {2'b01, 2'b00, 4'b1001, 2'b00, 6'b010011};
    kd1 = 30'h2A5C_3E91;
    kd2 = 30'h1FF0_0F0A;

    // R1: reset state, read and request ignored in reset
    tick(5);
    ctrl_chk("R1", 16'h0);
    chk("R1", {31'd0, sdo_pull}, 32'd0);
    key_ready = 1'b1; tick(1); key_ready = 1'b0;
    key_data = kd1;
    rd_frame(kd1, 1'b1, 1'b0, 1);
    chk("R1", {31'd0, sdo_pull}, 32'd0);
    rst_n = 1'b1; tick(6);
    chk("R1", {31'd0, sdo_pull}, 32'd0);
    ctrl_chk("R1", 16'h0);

    // R2 R3: full write, gap bits set to 1 and ignored; R6 line released
    addr_phase(8'h62, 8);
    pay_bits(p1, 0, 16, 6);
    ce_low();
    ctrl_chk("R2", p1);
    ctrl_chk("R3", p1);

    // R4: no update before bit 16, update at bit 16, extra bits ignored
    addr_phase(8'h62, 8);
    pay_bits(p2, 0, 10, 6);
    tick(6);
    ctrl_chk("R4", p1);
    pay_bits(p2, 10, 16, 6);
    tick(6);
    ctrl_chk("R4", p2);
    pay_bits(16'hFFFF, 0, 3, 6);
    ce_low();
    ctrl_chk("R4", p2);

    // R4: short frame ends with no change
    addr_phase(8'h62, 8);
    pay_bits(p1, 0, 12, 4);
    ce_low();
    ctrl_chk("R4", p2);

    // R10: only 7 address bits
    addr_phase(8'h62, 7);
    pay_bits(p1, 0, 16, 10);
    ce_low();
    ctrl_chk("R10", p2);

    // R9: unknown address
    addr_phase(8'h55, 8);
    pay_bits(p1, 0, 16, 9);
    ce_low();
    ctrl_chk("R9", p2);
    chk("R9", rd_cnt, 0);

    // R7: request raised by key_ready
    chk("R7", {31'd0, sdo_pull}, 32'd0);
    key_ready = 1'b1; tick(1); key_ready = 1'b0;
    tick(4);
    chk("R7", {31'd0, sdo_pull}, 32'd1);
    tick(20);
    chk("R7", {31'd0, sdo_pull}, 32'd1);

    // R5 R8: read shifts key data, completion clears request
    key_data = kd1;
    rd_frame(kd1, 1'b0, 1'b0, 5);
    chk("R8", rd_cnt, 1);
    chk("R8", {31'd0, sdo_pull}, 32'd0);

    // R11: key data changed mid read has no effect
    key_ready = 1'b1; tick(1); key_ready = 1'b0;
    tick(4);
    chk("R7", {31'd0, sdo_pull}, 32'd1);
    key_data = kd2;
    rd_frame(kd2, 1'b0, 1'b1, 11);
    chk("R8", rd_cnt, 2);
    chk("R8", {31'd0, sdo_pull}, 32'd0);
    ctrl_chk("R8", p2);

    tick(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule